// File: doc/BRIEF.md
# Credit-Gated Receive Frame Buffer

This block sits on the receive side of one Ethernet segment. It sits between the MAC receive datapath and the user application. Incoming 64-bit frame words arrive with start and end markers, a byte-count field, an error flag and a 24-bit status word. They are stored in a buffer and handed to the user with a valid/ready handshake. The user can stall the output at any time by holding ready low. An almost-full flag warns the user that the buffer is close to full.

The write side is gated by credit. After reset nothing is accepted. The user must first load a credit value and then send a separate start pulse. Each stored word spends one credit, and each word the user takes returns one. A frame that runs out of space is cut short: the block closes it with an end marker, the error flag and the overflow status bit. Loading credit again during operation does four things. It empties the buffer, abandons the frame being received and holds reception until the next start pulse. If the user had already taken part of a frame, it also closes that frame with an error word.

Top module: `rx_credit_fifo`

## Requirements
- R1: After reset `out_valid` and `rx_afull` are 0, and every incoming word is discarded until a `cred_load` pulse has been followed by a `cred_go` pulse.
- R2: A `cred_go` pulse with no `cred_load` before it has no effect. Between a `cred_load` and the next `cred_go`, all incoming words are discarded.
- R3: Accepted words leave in arrival order with data, `sop`, `eop`, `mod`, `err` and `stat` unchanged. A word that is neither inside an accepted frame nor marked `sop` is discarded.
- R4: `mod` passes through unchanged. A value of 0 means all 8 bytes of the last word are valid, and a value n from 1 to 7 means only the low n bytes are valid.
- R5: While `out_valid`=1 and `out_ready`=0, every output stays stable on the next cycle.
- R6: `rx_afull` is 1 exactly when the number of free buffer slots is AFULL_FREE (default 15) or fewer.
- R7: The credit counter is set by `cred_load`. It falls by one for each stored word and rises by one for each word taken from the buffer. No word is stored while credit is 0.
- R8: When only one slot remains and a word without `eop` arrives, that word is stored as the frame's last word. This holds whether the buffer is full or credit is used up. "Slot" means the smaller of free buffer entries and credit. The stored word has `eop`=1, `err`=1, `mod`=0 and `stat` bit 3 set. The rest of the frame is discarded up to the next `sop`.
- R9: A word marked `sop` that arrives with no slot left is discarded, together with the rest of its frame.
- R10: A `cred_load` pulse empties the buffer and aborts the frame being received. Reception stays blocked until the next `cred_go`.
- R11: If a frame's `sop` word has been taken but its `eop` word has not when `cred_load` occurs, the next output word closes the frame. That word has `eop`=1, `err`=1, `sop`=0, `mod`=0, data 0 and `stat`=24'h000008.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Incoming word present |
| in_sop | input | 1 | Incoming word starts a frame |
| in_eop | input | 1 | Incoming word ends a frame |
| in_mod | input | 6 | Valid byte count of the last word (0 = all) |
| in_err | input | 1 | Frame error, with the last word |
| in_stat | input | 24 | Frame status, with the last word |
| in_data | input | 64 | Incoming data word |
| cred_load | input | 1 | Load credit, flush, block reception |
| cred_val | input | CRED_W | Credit value loaded by `cred_load` |
| cred_go | input | 1 | Start reception after a load |
| out_valid | output | 1 | Output word present |
| out_ready | input | 1 | User takes the output word |
| out_sop | output | 1 | Output word starts a frame |
| out_eop | output | 1 | Output word ends a frame |
| out_mod | output | 6 | Valid byte count of the last word |
| out_err | output | 1 | Frame error |
| out_stat | output | 24 | Frame status |
| out_data | output | 64 | Output data word |
| rx_afull | output | 1 | Few free slots remain |

## Verification
The bench builds the block with DEPTH=24, AFULL_FREE=15 and CRED_W=6. With these values the almost-full threshold falls at nine stored words, which a short frame reaches. A full buffer is reached in 24 writes. A 6-bit credit can also exceed the depth, so the bench drives buffer-limited truncation and credit-limited truncation separately. The small depth also lets the bench drain the whole buffer and count its words.

// File: rtl/rx_cf_pkg.sv
package rx_cf_pkg;

  localparam int WORD_W  = 64;
  localparam int MOD_W   = 6;
  localparam int STAT_W  = 24;
  localparam int OVF_BIT = 3;

  typedef struct packed {
    logic              sop;
    logic              eop;
    logic [MOD_W-1:0]  mod;
    logic              err;
    logic [STAT_W-1:0] stat;
    logic [WORD_W-1:0] data;
  } cf_word_t;

  // slots usable by the writer: the tighter of buffer space and credit
  function automatic int room_of(input int free_slots, input int credit);
    return (free_slots < credit) ? free_slots : credit;
  endfunction

  function automatic logic afull_of(input int used, input int depth, input int slack);
    return (depth - used) <= slack;
  endfunction

  function automatic cf_word_t truncate_word(input cf_word_t w);
    cf_word_t t;
    t = w;
    t.eop = 1'b1;
    t.err = 1'b1;
    t.mod = '0;
    t.stat[OVF_BIT] = 1'b1;
    return t;
  endfunction

  function automatic cf_word_t close_word();
    cf_word_t t;
    t = '0;
    t.eop = 1'b1;
    t.err = 1'b1;
    t.stat[OVF_BIT] = 1'b1;
    return t;
  endfunction

endpackage

// File: rtl/rx_cf_store.sv
module rx_cf_store
  import rx_cf_pkg::*;
#(
  parameter int DEPTH = 32,
  localparam int AW = $clog2(DEPTH),
  localparam int UW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          wr_en,
  input  cf_word_t      wr_word,
  input  logic          rd_en,
  output cf_word_t      rd_word,
  output logic [UW-1:0] used
);

  cf_word_t        mem [DEPTH];
  logic [AW-1:0]   wp, rp;

  function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (wr_en && !flush) mem[wp] <= wr_word;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      wp   <= '0;
      rp   <= '0;
      used <= '0;
    end else begin
      if (wr_en) wp <= step(wp);
      if (rd_en) rp <= step(rp);
      used <= used + UW'(wr_en) - UW'(rd_en);
    end
  end

  assign rd_word = mem[rp];

endmodule

// File: rtl/rx_cf_admit.sv
module rx_cf_admit
  import rx_cf_pkg::*;
#(
  parameter int DEPTH  = 32,
  parameter int CRED_W = 7,
  localparam int UW = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              in_sop,
  input  logic              in_eop,
  input  logic [MOD_W-1:0]  in_mod,
  input  logic              in_err,
  input  logic [STAT_W-1:0] in_stat,
  input  logic [WORD_W-1:0] in_data,
  input  logic              cred_load,
  input  logic [CRED_W-1:0] cred_val,
  input  logic              cred_go,
  input  logic [UW-1:0]     used,
  input  logic              rd_en,
  output logic              wr_en,
  output logic              wr_trunc,
  output cf_word_t          wr_word,
  output logic              rx_en,
  output logic [CRED_W-1:0] credit
);

  logic     armed_q, in_frame_q, in_frame_n;
  int       room;
  cf_word_t raw;

  assign room = room_of(DEPTH - int'(used), int'(credit));
  assign raw  = '{sop: in_sop, eop: in_eop, mod: in_mod, err: in_err,
                  stat: in_stat, data: in_data};

  always_comb begin
    wr_en      = 1'b0;
    wr_trunc   = 1'b0;
    in_frame_n = in_frame_q;
    if (in_valid && rx_en && !cred_load && (in_sop || in_frame_q)) begin
      if (room == 0) begin
        in_frame_n = 1'b0;
      end else begin
        wr_en      = 1'b1;
        wr_trunc   = (room == 1) && !in_eop;
        in_frame_n = !in_eop && !wr_trunc;
      end
    end
    wr_word = wr_trunc ? truncate_word(raw) : raw;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_en      <= 1'b0;
      armed_q    <= 1'b0;
      in_frame_q <= 1'b0;
      credit     <= '0;
    end else if (cred_load) begin
      rx_en      <= 1'b0;
      armed_q    <= 1'b1;
      in_frame_q <= 1'b0;
      credit     <= cred_val;
    end else begin
      if (cred_go && armed_q) begin
        rx_en   <= 1'b1;
        armed_q <= 1'b0;
      end
      in_frame_q <= in_frame_n;
      credit     <= credit + CRED_W'(rd_en) - CRED_W'(wr_en);
    end
  end

endmodule

// File: rtl/rx_cf_egress.sv
module rx_cf_egress
  import rx_cf_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     cred_load,
  input  logic     empty,
  input  cf_word_t head,
  input  logic     out_ready,
  output logic     out_valid,
  output cf_word_t out_word,
  output logic     rd_en,
  output logic     close_sel
);

  logic open_q, open_n, close_q, hs;

  assign close_sel = close_q;
  assign out_valid = close_q || !empty;
  assign out_word  = close_q ? close_word() : head;
  assign hs        = out_valid && out_ready;
  assign rd_en     = hs && !close_q;

  always_comb begin
    open_n = open_q;
    if (hs) begin
      if (close_q)                   open_n = 1'b0;
      else if (head.eop)             open_n = 1'b0;
      else if (head.sop)             open_n = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      open_q  <= 1'b0;
      close_q <= 1'b0;
    end else if (cred_load) begin
      open_q  <= 1'b0;
      close_q <= (close_q && !hs) || open_n;
    end else begin
      open_q  <= open_n;
      close_q <= close_q && !hs;
    end
  end

endmodule

// File: rtl/rx_credit_fifo.sv
module rx_credit_fifo
  import rx_cf_pkg::*;
#(
  parameter int DEPTH      = 32,
  parameter int AFULL_FREE = 15,
  parameter int CRED_W     = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              in_sop,
  input  logic              in_eop,
  input  logic [5:0]        in_mod,
  input  logic              in_err,
  input  logic [23:0]       in_stat,
  input  logic [63:0]       in_data,
  input  logic              cred_load,
  input  logic [CRED_W-1:0] cred_val,
  input  logic              cred_go,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              out_sop,
  output logic              out_eop,
  output logic [5:0]        out_mod,
  output logic              out_err,
  output logic [23:0]       out_stat,
  output logic [63:0]       out_data,
  output logic              rx_afull
);

  localparam int UW = $clog2(DEPTH + 1);

  logic              wr_en, wr_trunc, rd_en, rx_en, close_sel;
  cf_word_t          wr_word, rd_word, out_word;
  logic [UW-1:0]     used;
  logic [CRED_W-1:0] credit;

  rx_cf_admit #(.DEPTH(DEPTH), .CRED_W(CRED_W)) admit_i (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_sop(in_sop), .in_eop(in_eop), .in_mod(in_mod),
    .in_err(in_err), .in_stat(in_stat), .in_data(in_data),
    .cred_load(cred_load), .cred_val(cred_val), .cred_go(cred_go),
    .used(used), .rd_en(rd_en),
    .wr_en(wr_en), .wr_trunc(wr_trunc), .wr_word(wr_word),
    .rx_en(rx_en), .credit(credit)
  );

  rx_cf_store #(.DEPTH(DEPTH)) store_i (
    .clk(clk), .rst_n(rst_n), .flush(cred_load),
    .wr_en(wr_en), .wr_word(wr_word),
    .rd_en(rd_en), .rd_word(rd_word), .used(used)
  );

  rx_cf_egress egress_i (
    .clk(clk), .rst_n(rst_n), .cred_load(cred_load),
    .empty(used == '0), .head(rd_word), .out_ready(out_ready),
    .out_valid(out_valid), .out_word(out_word),
    .rd_en(rd_en), .close_sel(close_sel)
  );

  assign out_sop  = out_word.sop;
  assign out_eop  = out_word.eop;
  assign out_mod  = out_word.mod;
  assign out_err  = out_word.err;
  assign out_stat = out_word.stat;
  assign out_data = out_word.data;
  assign rx_afull = afull_of(int'(used), DEPTH, AFULL_FREE);

endmodule

// File: rtl/rx_credit_fifo_chk.sv
module rx_credit_fifo_chk
  import rx_cf_pkg::*;
#(
  parameter int DEPTH  = 32,
  parameter int CRED_W = 7,
  localparam int UW = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cred_load,
  input logic              wr_en,
  input logic              wr_trunc,
  input cf_word_t          wr_word,
  input logic              rx_en,
  input logic [CRED_W-1:0] credit,
  input logic [UW-1:0]     used,
  input logic              close_sel,
  input logic              out_valid,
  input logic              out_ready,
  input logic              out_sop,
  input logic              out_eop,
  input logic              out_err,
  input logic [23:0]       out_stat,
  input logic [63:0]       out_data,
  input logic              rx_afull
);

  p_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> rx_en);

  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !cred_load) |=>
      (out_valid && $stable(out_data) && $stable(out_eop) && $stable(out_sop)
       && $stable(out_stat) && $stable(out_err)));

  p_afull_hi_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (used == UW'(DEPTH)) |-> rx_afull);

  p_afull_lo_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (used == '0) |-> !rx_afull);

  p_credit_guard_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (credit != '0));

  p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (used == UW'(DEPTH)) |-> !wr_en);

  p_trunc_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_trunc) |-> (wr_word.eop && wr_word.err && wr_word.stat[OVF_BIT]));

  p_flush_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cred_load |=> ((used == '0) && !rx_en));

  p_close_r11: assert property (@(posedge clk) disable iff (!rst_n)
    close_sel |-> (out_valid && out_eop && out_err && !out_sop));

endmodule

bind rx_credit_fifo rx_credit_fifo_chk #(.DEPTH(DEPTH), .CRED_W(CRED_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .cred_load(cred_load),
  .wr_en(wr_en), .wr_trunc(wr_trunc), .wr_word(wr_word),
  .rx_en(rx_en), .credit(credit), .used(used), .close_sel(close_sel),
  .out_valid(out_valid), .out_ready(out_ready), .out_sop(out_sop),
  .out_eop(out_eop), .out_err(out_err), .out_stat(out_stat),
  .out_data(out_data), .rx_afull(rx_afull)
);

// File: tb/rx_credit_fifo_tb_top.sv
module rx_credit_fifo_tb_top;

  localparam int DEPTH = 24;
  localparam int AFF   = 15;
  localparam int CW    = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 0, in_sop = 0, in_eop = 0, in_err = 0;
  logic [5:0]  in_mod = '0;
  logic [23:0] in_stat = '0;
  logic [63:0] in_data = '0;
  logic cred_load = 0, cred_go = 0, out_ready = 0;
  logic [CW-1:0] cred_val = '0;
  logic out_valid, out_sop, out_eop, out_err, rx_afull;
  logic [5:0]  out_mod;
  logic [23:0] out_stat;
  logic [63:0] out_data;

  int nchk = 0, nerr = 0;
  logic pw_sop, pw_eop, pw_err;
  logic [5:0]  pw_mod;
  logic [23:0] pw_stat;
  logic [63:0] pw_data;
  int dn;

  always #2.5 clk = ~clk;

  rx_credit_fifo #(.DEPTH(DEPTH), .AFULL_FREE(AFF), .CRED_W(CW)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_sop(in_sop), .in_eop(in_eop), .in_mod(in_mod),
    .in_err(in_err), .in_stat(in_stat), .in_data(in_data),
    .cred_load(cred_load), .cred_val(cred_val), .cred_go(cred_go),
    .out_valid(out_valid), .out_ready(out_ready), .out_sop(out_sop),
    .out_eop(out_eop), .out_mod(out_mod), .out_err(out_err),
    .out_stat(out_stat), .out_data(out_data), .rx_afull(rx_afull)
  );

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic send(input logic s, input logic e, input logic [5:0] m,
                      input logic er, input logic [23:0] st, input logic [63:0] d);
    in_valid = 1; in_sop = s; in_eop = e; in_mod = m; in_err = er;
    in_stat = st; in_data = d;
    @(negedge clk);
    in_valid = 0; in_sop = 0; in_eop = 0; in_mod = '0; in_err = 0;
    in_stat = '0; in_data = '0;
  endtask

  task automatic load(input int v);
    cred_load = 1; cred_val = CW'(v);
    @(negedge clk);
    cred_load = 0;
  endtask

  task automatic go();
    cred_go = 1;
    @(negedge clk);
    cred_go = 0;
  endtask

  task automatic pop();
    pw_sop = out_sop; pw_eop = out_eop; pw_err = out_err;
    pw_mod = out_mod; pw_stat = out_stat; pw_data = out_data;
    out_ready = 1;
    @(negedge clk);
    out_ready = 0;
  endtask

  task automatic drain();
    dn = 0;
    while (out_valid && dn < 64) begin
      pop();
      dn++;
    end
  endtask

  task automatic t_reset();
    chk("R1", "out_valid after reset", 64'(out_valid), 0);
    chk("R1", "afull after reset", 64'(rx_afull), 0);
    send(1, 1, 0, 0, 0, 64'h11);
    chk("R1", "frame before load dropped", 64'(out_valid), 0);
  endtask

  task automatic t_gate();
    go();
    send(1, 1, 0, 0, 0, 64'h22);
    chk("R2", "go without load ignored", 64'(out_valid), 0);
    load(24);
    send(1, 1, 0, 0, 0, 64'h33);
    chk("R2", "frame between load and go dropped", 64'(out_valid), 0);
    go();
    send(0, 1, 0, 0, 0, 64'h44);
    chk("R3", "word outside frame dropped", 64'(out_valid), 0);
  endtask

  task automatic t_pass();
    send(1, 0, 0, 0, 0, 64'hA0);
    send(0, 0, 0, 0, 0, 64'hA1);
    send(0, 1, 6'd3, 1, 24'h123402, 64'hA2);
    pop();
    chk("R3", "w0 data", pw_data, 64'hA0);
    chk("R3", "w0 sop/eop", {pw_sop, pw_eop}, 2'b10);
    pop();
    chk("R3", "w1 data", pw_data, 64'hA1);
    pop();
    chk("R3", "w2 data", pw_data, 64'hA2);
    chk("R4", "w2 mod", pw_mod, 3);
    chk("R3", "w2 eop/err", {pw_eop, pw_err}, 2'b11);
    chk("R3", "w2 stat", pw_stat, 24'h123402);
    chk("R3", "empty after frame", 64'(out_valid), 0);
    send(1, 1, 0, 0, 24'h004000, 64'hB0);
    pop();
    chk("R4", "mod 0 whole word", pw_mod, 0);
  endtask

  task automatic t_hold();
    send(1, 1, 6'd7, 0, 24'h00AB00, 64'hC0FFEE);
    repeat (3) @(negedge clk);
    chk("R5", "valid held", 64'(out_valid), 1);
    chk("R5", "data held", out_data, 64'hC0FFEE);
    chk("R5", "mod held", out_mod, 7);
    pop();
  endtask

  task automatic t_afull();
    for (int i = 0; i < 8; i++) send(i == 0, i == 7, 0, 0, 0, 64'(i));
    chk("R6", "afull with 16 free", 64'(rx_afull), 0);
    send(1, 1, 0, 0, 0, 64'h99);
    chk("R6", "afull with 15 free", 64'(rx_afull), 1);
    pop();
    chk("R6", "afull clears at 16 free", 64'(rx_afull), 0);
    drain();
    chk("R6", "remaining words", dn, 8);
  endtask

  task automatic t_credit();
    load(3); go();
    for (int i = 0; i < 5; i++) send(i == 0, i == 4, 0, 0, 24'h000100, 64'hD0 + 64'(i));
    send(1, 1, 0, 0, 0, 64'hEE);
    drain();
    chk("R7", "words stored with credit 3", dn, 3);
    chk("R8", "truncated word data", pw_data, 64'hD2);
    chk("R8", "truncated eop/err", {pw_eop, pw_err}, 2'b11);
    chk("R8", "truncated stat", pw_stat, 24'h000108);
    chk("R9", "sop with no room dropped", 64'(out_valid), 0);
    send(1, 1, 0, 0, 0, 64'hF1);
    pop();
    chk("R7", "credit returned by reads", pw_data, 64'hF1);
  endtask

  task automatic t_full();
    load(31); go();
    for (int i = 0; i < 26; i++) send(i == 0, i == 25, 6'd5, 0, 0, 64'(i));
    chk("R6", "afull when full", 64'(rx_afull), 1);
    drain();
    chk("R8", "words stored when buffer full", dn, 24);
    chk("R8", "last stored word", pw_data, 23);
    chk("R8", "full trunc eop/err/mod", {pw_eop, pw_err, pw_mod}, {2'b11, 6'd0});
  endtask

  task automatic t_flush();
    load(24); go();
    for (int i = 0; i < 4; i++) send(i == 0, i == 3, 0, 0, 0, 64'h50 + 64'(i));
    pop(); pop();
    load(24);
    chk("R11", "closing word valid", 64'(out_valid), 1);
    pop();
    chk("R11", "closing sop/eop/err", {pw_sop, pw_eop, pw_err}, 3'b011);
    chk("R11", "closing stat", pw_stat, 24'h000008);
    chk("R11", "closing data", pw_data, 0);
    chk("R10", "buffer flushed", 64'(out_valid), 0);
    send(1, 1, 0, 0, 0, 64'h61);
    chk("R10", "blocked until go", 64'(out_valid), 0);
    go();
    send(1, 1, 0, 0, 0, 64'h62);
    pop();
    chk("R10", "reception resumes", pw_data, 64'h62);
    send(1, 0, 0, 0, 0, 64'h70);
    load(24); go();
    send(0, 1, 0, 0, 0, 64'h71);
    chk("R10", "aborted frame tail dropped", 64'(out_valid), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_gate();
    t_pass();
    t_hold();
    t_afull();
    t_credit();
    t_full();
    t_flush();
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    nerr++; nchk++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

endmodule